// File: doc/BRIEF.md
# Gated Cascaded Event Counter

This block counts transitions on an asynchronous event pin and returns a wide count built from two chained stages. A narrow prescaler stage counts accepted events up to its compare value and then wraps. Its compare match is the only thing that advances a wider upper stage. The upper stage wraps at its own compare value. A second upper compare raises its own interrupt. When the prescaler compare is set to all ones, the pair behaves as one 24-bit event counter.

A small duty-cycle timer can generate an acceptance window. When gating is switched on, edges on the pin are counted only while that window is high. This allows events to be counted in periodic bursts. Each of the three stages has its own run bit and keeps its state while stopped. Software normally starts them in this order: upper stage, then prescaler, then window timer.

Each of the three interrupts is a single-cycle pulse with its own mask. In the full-width mode, the prescaler interrupt is meant to stay masked.

Top module: `evc_cascade_counter`

## Requirements
- R1: After reset, `count` is zero and all three interrupt outputs are low. The window timer counter is zero, and `gate_out` is high while the window timer is stopped.
- R2: The pin passes through a two-flop synchronizer. An edge is taken from the synchronized level, and an accepted edge shows in `count` on the third rising clock edge after the pin change. `edge_sel` selects the edge: 2'b00 counts falling edges, 2'b01 counts rising edges, and 2'b10 and 2'b11 count nothing. At most one event is counted per clock.
- R3: The prescaler with compare value C counts accepted events 0,1,…,C. The next accepted event clears it to 0 and produces a match. With C = 8'hFF, there is one match every 256 events.
- R4: The upper stage advances by exactly one for each prescaler match and for nothing else.
- R5: When the upper stage advances while equal to `hi_cmp_a`, it clears to 0. In the same edge it raises a one-cycle `hi_irq_a` pulse. With `hi_cmp_a` = 16'hFFFF, the upper stage uses its full range.
- R6: `hi_irq_b` pulses for one cycle on each upper-stage advance whose new value equals `hi_cmp_b`.
- R7: A mask bit of 1 suppresses its interrupt pulse and has no effect on the counts.
- R8: While its run bit is 0, each stage holds its count. A stopped upper stage ignores prescaler matches, but those matches still raise `lo_irq`.
- R9: The window timer, when running with period N and duty M (0 ≤ M < N), counts 0..N and then returns to 0. `gate_out` is high while the timer count is below M and low from M up to N. While stopped, the timer holds its count and `gate_out` is high.
- R10: With `gate_on` = 1, an edge is accepted only in a cycle where `gate_out` is high. With `gate_on` = 0, every selected edge is accepted.
- R11: `count` is the upper stage in bits [23:8] and the prescaler in bits [7:0].
- R12: `lo_irq` is a one-cycle pulse, registered at the same edge where the prescaler clears on a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pin | input | 1 | Asynchronous event pin |
| edge_sel | input | 2 | Edge select (00 falling, 01 rising, others none) |
| lo_run | input | 1 | Prescaler run bit |
| hi_run | input | 1 | Upper stage run bit |
| win_run | input | 1 | Window timer run bit |
| gate_on | input | 1 | Gate events with the window |
| lo_cmp | input | 8 | Prescaler compare value |
| hi_cmp_a | input | 16 | Upper stage clear compare |
| hi_cmp_b | input | 16 | Upper stage secondary compare |
| win_period | input | 8 | Window timer period N |
| win_duty | input | 8 | Window timer duty M |
| lo_mask | input | 1 | Mask for `lo_irq` |
| hi_mask_a | input | 1 | Mask for `hi_irq_a` |
| hi_mask_b | input | 1 | Mask for `hi_irq_b` |
| count | output | 24 | Combined count {upper, prescaler} |
| lo_irq | output | 1 | Prescaler match pulse |
| hi_irq_a | output | 1 | Upper clear-compare match pulse |
| hi_irq_b | output | 1 | Upper secondary-compare match pulse |
| gate_out | output | 1 | Window timer output |

## Verification
The bench sweeps the prescaler compare over several small values and over all ones. For each, it compares the prescaler count, the upper count and the number of prescaler pulses against integer division and remainder of the event count. An off-by-one compare would miss these values on every sweep point. Short upper-compare settings check the wrap and the secondary pulses, so a stage that wraps one value late or fires on the old value instead of the new one shows up in the pulse totals. The window is traced cycle by cycle, and it is also parked in its low region while stopped, so a timer that resets or drops its output when stopped is caught. A zero duty with gating on must block every event; a design that ignored the gate would count them.

// File: rtl/evc_pkg.sv
package evc_pkg;
    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_NONE_A = 2'b10,
        EDGE_NONE_B = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/evc_edge_sync.sv
module evc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    output logic       evt_o
);
    import evc_pkg::*;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     lvl;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        lvl       = st_q.sync[SYNC_STAGES-1];
        unique case (edge_sel_e'(edge_sel_i))
            EDGE_FALL: evt_o = !lvl && st_q.prev;
            EDGE_RISE: evt_o = lvl && !st_q.prev;
            default:   evt_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evc_gate_timer.sv
module evc_gate_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] duty_i,
    output logic         gate_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i) begin
            if (st_q.cnt == period_i) st_d.cnt = '0;
            else                      st_d.cnt = st_q.cnt + 1'b1;
        end
        gate_o = run_i ? (st_q.cnt < duty_i) : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> $stable(st_q.cnt)); // R9
endmodule

// File: rtl/evc_low_stage.sv
module evc_low_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         evt_i,
    input  logic [W-1:0] cmp_i,
    input  logic         mask_i,
    output logic [W-1:0] cnt_o,
    output logic         match_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq;
    } low_st_t;

    low_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d    = st_q;
        hit     = run_i && evt_i;
        match_o = hit && (st_q.cnt == cmp_i);
        if (match_o)  st_d.cnt = '0;
        else if (hit) st_d.cnt = st_q.cnt + 1'b1;
        st_d.irq = match_o && !mask_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign irq_o = st_q.irq;

    AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> $stable(st_q.cnt)); // R8
    AST_LOW_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (st_q.cnt == '0)); // R12
endmodule

// File: rtl/evc_high_stage.sv
module evc_high_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic [W-1:0] cmp_a_i,
    input  logic [W-1:0] cmp_b_i,
    input  logic         mask_a_i,
    input  logic         mask_b_i,
    output logic [W-1:0] cnt_o,
    output logic         irq_a_o,
    output logic         irq_b_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq_a;
        logic         irq_b;
    } high_st_t;

    high_st_t     st_d, st_q;
    logic         adv, clr;
    logic [W-1:0] nxt;

    always_comb begin
        st_d = st_q;
        adv  = run_i && tick_i;
        clr  = adv && (st_q.cnt == cmp_a_i);
        nxt  = clr ? '0 : st_q.cnt + 1'b1;
        if (adv) st_d.cnt = nxt;
        st_d.irq_a = clr && !mask_a_i;
        st_d.irq_b = adv && (nxt == cmp_b_i) && !mask_b_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign irq_a_o = st_q.irq_a;
    assign irq_b_o = st_q.irq_b;

    AST_HIGH_MASK_A: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a_o |-> !$past(mask_a_i)); // R7
    AST_HIGH_B_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b_o |-> (st_q.cnt == $past(cmp_b_i))); // R6
endmodule

// File: rtl/evc_cascade_counter.sv
module evc_cascade_counter #(
    parameter int LOW_W       = 8,
    parameter int HIGH_W      = 16,
    parameter int GATE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_pin,
    input  logic [1:0]              edge_sel,
    input  logic                    lo_run,
    input  logic                    hi_run,
    input  logic                    win_run,
    input  logic                    gate_on,
    input  logic [LOW_W-1:0]        lo_cmp,
    input  logic [HIGH_W-1:0]       hi_cmp_a,
    input  logic [HIGH_W-1:0]       hi_cmp_b,
    input  logic [GATE_W-1:0]       win_period,
    input  logic [GATE_W-1:0]       win_duty,
    input  logic                    lo_mask,
    input  logic                    hi_mask_a,
    input  logic                    hi_mask_b,
    output logic [LOW_W+HIGH_W-1:0] count,
    output logic                    lo_irq,
    output logic                    hi_irq_a,
    output logic                    hi_irq_b,
    output logic                    gate_out
);
    localparam int CNT_W = LOW_W + HIGH_W;

    logic              raw_evt, acc_evt, lo_match;
    logic [LOW_W-1:0]  lo_cnt;
    logic [HIGH_W-1:0] hi_cnt;

    evc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(evt_pin),
        .edge_sel_i(edge_sel), .evt_o(raw_evt)
    );

    evc_gate_timer #(.W(GATE_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .run_i(win_run),
        .period_i(win_period), .duty_i(win_duty), .gate_o(gate_out)
    );

    assign acc_evt = raw_evt && (!gate_on || gate_out);

    evc_low_stage #(.W(LOW_W)) u_low (
        .clk(clk), .rst_n(rst_n), .run_i(lo_run), .evt_i(acc_evt),
        .cmp_i(lo_cmp), .mask_i(lo_mask), .cnt_o(lo_cnt),
        .match_o(lo_match), .irq_o(lo_irq)
    );

    evc_high_stage #(.W(HIGH_W)) u_high (
        .clk(clk), .rst_n(rst_n), .run_i(hi_run), .tick_i(lo_match),
        .cmp_a_i(hi_cmp_a), .cmp_b_i(hi_cmp_b),
        .mask_a_i(hi_mask_a), .mask_b_i(hi_mask_b),
        .cnt_o(hi_cnt), .irq_a_o(hi_irq_a), .irq_b_o(hi_irq_b)
    );

    assign count = CNT_W'({hi_cnt, lo_cnt});

    AST_HIGH_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hi_cnt) |-> $past(lo_match)); // R4
    AST_LOW_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lo_cnt) |-> (lo_cnt == $past(lo_cnt) + 1'b1) || (lo_cnt == '0)); // R3
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && !gate_out && raw_evt) |=> $stable(lo_cnt)); // R10
endmodule

// File: tb/sim_evc_cascade_counter.sv
module sim_evc_cascade_counter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pin = 1'b0;
    logic [1:0]  edge_sel = 2'b01;
    logic        lo_run = 1'b0, hi_run = 1'b0, win_run = 1'b0, gate_on = 1'b0;
    logic [7:0]  lo_cmp = 8'hFF;
    logic [15:0] hi_cmp_a = 16'hFFFF, hi_cmp_b = 16'hFFFF;
    logic [7:0]  win_period = 8'd5, win_duty = 8'd2;
    logic        lo_mask = 1'b0, hi_mask_a = 1'b0, hi_mask_b = 1'b0;
    logic [23:0] count;
    logic        lo_irq, hi_irq_a, hi_irq_b, gate_out;

    int tests = 0, fails = 0;
    int n_lo = 0, n_a = 0, n_b = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evc_cascade_counter u0 (
        .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .edge_sel(edge_sel),
        .lo_run(lo_run), .hi_run(hi_run), .win_run(win_run), .gate_on(gate_on),
        .lo_cmp(lo_cmp), .hi_cmp_a(hi_cmp_a), .hi_cmp_b(hi_cmp_b),
        .win_period(win_period), .win_duty(win_duty),
        .lo_mask(lo_mask), .hi_mask_a(hi_mask_a), .hi_mask_b(hi_mask_b),
        .count(count), .lo_irq(lo_irq), .hi_irq_a(hi_irq_a), .hi_irq_b(hi_irq_b),
        .gate_out(gate_out)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (lo_irq)   n_lo <= n_lo + 1;
            if (hi_irq_a) n_a  <= n_a + 1;
            if (hi_irq_b) n_b  <= n_b + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        evt_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            evt_pin = 1'b1;
            repeat (4) @(negedge clk);
            evt_pin = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        int b_lo, b_a, b_b, bad;
        int cmps[5] = '{0, 1, 3, 7, 255};
        int evs[5]  = '{20, 21, 19, 40, 300};
        do_reset();
        // R1 reset state
        chk("R1 count", int'(count), 0);
        chk("R1 irqs", int'({lo_irq, hi_irq_a, hi_irq_b}), 0);
        chk("R1 gate idle high", int'(gate_out), 1);

        // R2 rising edges, R11 layout
        lo_run = 1; hi_run = 1;
        pulses(5);
        chk("R2 rising", int'(count), 5);
        // R2 falling edge select
        do_reset();
        edge_sel = 2'b00;
        evt_pin = 1'b1; repeat (4) @(negedge clk);
        chk("R2 falling ignores rise", int'(count), 0);
        evt_pin = 1'b0; repeat (4) @(negedge clk);
        chk("R2 falling counts fall", int'(count), 1);
        // R2 code 10 counts nothing
        do_reset();
        edge_sel = 2'b10;
        pulses(4);
        chk("R2 code 10 none", int'(count), 0);
        edge_sel = 2'b01;

        // R3 R4 R12 R11 sweep of prescaler compare
        for (int k = 0; k < 5; k++) begin
            do_reset();
            lo_cmp = 8'(cmps[k]);
            b_lo = n_lo;
            pulses(evs[k]);
            chk("R3 low count", int'(count[7:0]), evs[k] % (cmps[k] + 1));
            chk("R4 R11 upper count", int'(count[23:8]), evs[k] / (cmps[k] + 1));
            chk("R12 low irq pulses", n_lo - b_lo, evs[k] / (cmps[k] + 1));
        end

        // R5 R6 upper wrap and secondary compare
        do_reset();
        lo_cmp = 8'd1; hi_cmp_a = 16'd2; hi_cmp_b = 16'd1;
        b_a = n_a; b_b = n_b;
        pulses(14);
        chk("R5 upper wraps", int'(count[23:8]), 1);
        chk("R5 clear pulses", n_a - b_a, 2);
        chk("R6 secondary pulses", n_b - b_b, 3);

        // R7 masks suppress only interrupts
        do_reset();
        lo_mask = 1; hi_mask_a = 1; hi_mask_b = 1;
        b_lo = n_lo; b_a = n_a; b_b = n_b;
        pulses(14);
        chk("R7 count unaffected", int'(count), (1 << 8) | 0);
        chk("R7 all masked", (n_lo - b_lo) + (n_a - b_a) + (n_b - b_b), 0);
        lo_mask = 0; hi_mask_a = 0; hi_mask_b = 0;
        hi_cmp_a = 16'hFFFF; hi_cmp_b = 16'hFFFF;

        // R8 run bits
        do_reset();
        lo_run = 0; lo_cmp = 8'd0;
        pulses(5);
        chk("R8 low stopped", int'(count), 0);
        lo_run = 1; hi_run = 0;
        b_lo = n_lo;
        pulses(4);
        chk("R8 high stopped", int'(count), 0);
        chk("R8 low irq while high stopped", n_lo - b_lo, 4);
        hi_run = 1;
        pulses(2);
        chk("R8 high resumes", int'(count[23:8]), 2);

        // R9 window waveform
        do_reset();
        win_period = 8'd5; win_duty = 8'd2;
        win_run = 1;
        bad = 0;
        for (int j = 0; j <= 16; j++) begin
            if (gate_out !== (((j % 6) < 2) ? 1'b1 : 1'b0)) bad++;
            if (j < 16) @(negedge clk);
        end
        chk("R9 window trace mismatches", bad, 0);
        win_run = 0;
        #1;
        chk("R9 stopped output high", int'(gate_out), 1);
        repeat (5) @(negedge clk);
        win_run = 1;
        #1;
        chk("R9 count held while stopped", int'(gate_out), 0);
        @(negedge clk);
        chk("R9 resumes at period end", int'(gate_out), 0);
        @(negedge clk);
        chk("R9 wraps to zero", int'(gate_out), 1);

        // R10 gating
        do_reset();
        lo_cmp = 8'hFF;
        win_period = 8'd5; win_duty = 8'd0; win_run = 1; gate_on = 1;
        pulses(6);
        chk("R10 closed window blocks", int'(count), 0);
        gate_on = 0;
        pulses(3);
        chk("R10 ungated counts", int'(count), 3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule